// File: doc/BRIEF.md
# Strobed Overvoltage Fault Qualifier

This block decides whether an overvoltage condition seen on a switching converter is real. It watches the gate-drive signal and looks at a comparator output only inside a short sampling window. The window opens a fixed number of clock ticks after each turn-off edge of the power switch. The hold-off before the window lets the ringing that follows the auxiliary-winding edge die out before anything is sampled.

Every switching cycle ends with a verdict. A cycle is an overvoltage cycle if the comparator was seen high at any point in its window, and each such cycle adds one to a run counter. Any cycle without a trip clears the counter. When the run reaches the trip threshold, a fault latches and the gate output is held low until reset. The hold-off, window length, threshold and synchronizer depth are parameters, with times counted in clock ticks.

Top module: `ovfault_qualifier`

## Requirements
- R1: The strobe output goes high HOLDOFF_TICKS clocks after the clock edge that first samples gateIn low following a high, and it stays high for WINDOW_TICKS clocks while gateIn remains low.
- R2: cmpIn passes through a two-flop synchronizer. A one-clock pulse on cmpIn, sampled i clocks after the falling-edge clock, counts for the cycle if and only if HOLDOFF_TICKS-1 <= i <= HOLDOFF_TICKS+WINDOW_TICKS-2.
- R3: The cycle verdict is applied when the window closes. A cycle with a trip adds one to tripCount.
- R4: A cycle with no trip inside its window sets tripCount to 0. Two tripping cycles followed by a clean one leave tripCount at 0 and faultLatched at 0.
- R5: faultLatched goes to 1 at the verdict that brings tripCount to TRIP_COUNT. Further tripping cycles hold tripCount at TRIP_COUNT.
- R6: If gateIn returns high while the window is open, strobe drops at once and the window closes. The verdict then uses only the samples taken before the rise.
- R7: If gateIn returns high during the hold-off, the cycle ends with a no-trip verdict, whatever cmpIn did.
- R8: Once set, faultLatched stays at 1 until reset, and gateOut is held at 0 whatever gateIn does.
- R9: After reset, strobe, tripCount and faultLatched are all 0.
- R10: While faultLatched is 0, gateOut equals gateIn in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateIn | input | 1 | Gate-drive request, synchronous to clk; high means the switch is on |
| cmpIn | input | 1 | Asynchronous overvoltage comparator output |
| gateOut | output | 1 | Gate drive after fault blanking |
| strobe | output | 1 | High while the comparator is being sampled |
| tripCount | output | CNT_W | Number of consecutive tripping cycles |
| faultLatched | output | 1 | Sticky overvoltage fault |

## Verification
The bench moves a single-clock comparator pulse across every offset of a switching cycle. This finds a window that is shifted or one clock too wide or narrow, and a synchronizer latency different from two flops; any of these would count a pulse just outside the window or miss one just inside it. Runs of tripping cycles broken by a clean cycle catch a counter that only increments and never clears on a miss. A four-cycle run catches a fault that sets late, a fault that fails to stick, and a gate output that is not blanked. Gate rises during the window and during the hold-off catch a design that keeps sampling after turn-on or that carries a stale hit into the verdict.

// File: rtl/ovq_pkg.sv
package ovq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HOLDOFF = 2'd1,
    ST_WINDOW  = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;  // comparator may be looked at this cycle
    logic close;   // switching cycle ends; apply verdict
  } qualCtrl_t;
endpackage

// File: rtl/ovq_control.sv
module ovq_control
  import ovq_pkg::*;
#(
  parameter int HOLDOFF_TICKS = 200,
  parameter int WINDOW_TICKS  = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      gateIn,
  output qualCtrl_t ctrl,
  output logic      strobe
);
  localparam int MAX_TICKS = (HOLDOFF_TICKS > WINDOW_TICKS) ? HOLDOFF_TICKS : WINDOW_TICKS;
  localparam int TMR_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;
  localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLDOFF_TICKS - 1);
  localparam logic [TMR_W-1:0] WIN_LAST  = TMR_W'(WINDOW_TICKS - 1);

  phase_e            phase, phaseNext;
  logic [TMR_W-1:0]  timer, timerNext;
  logic              gatePrev;
  logic              fallSeen;
  logic              closeNow;

  assign fallSeen = gatePrev & ~gateIn;

  always_comb begin
    phaseNext = phase;
    timerNext = timer;
    closeNow  = 1'b0;
    unique case (phase)
      ST_IDLE: begin
        if (fallSeen) begin
          phaseNext = ST_HOLDOFF;
          timerNext = '0;
        end
      end
      ST_HOLDOFF: begin
        if (gateIn) begin
          phaseNext = ST_IDLE;
          closeNow  = 1'b1;
        end else if (timer == HOLD_LAST) begin
          phaseNext = ST_WINDOW;
          timerNext = '0;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_WINDOW: begin
        if (gateIn || (timer == WIN_LAST)) begin
          phaseNext = ST_IDLE;
          closeNow  = 1'b1;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      timer    <= '0;
      gatePrev <= 1'b0;
    end else begin
      phase    <= phaseNext;
      timer    <= timerNext;
      gatePrev <= gateIn;
    end
  end

  assign strobe      = (phase == ST_WINDOW) & ~gateIn;
  assign ctrl.sample = strobe;
  assign ctrl.close  = closeNow;
endmodule

// File: rtl/ovq_datapath.sv
module ovq_datapath
  import ovq_pkg::*;
#(
  parameter int TRIP_COUNT  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  input  logic             gateIn,
  input  qualCtrl_t        ctrl,
  output logic [CNT_W-1:0] tripCount,
  output logic             faultLatched,
  output logic             gateOut
);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TRIP_COUNT);
  localparam logic [CNT_W-1:0] CNT_PREV = CNT_W'(TRIP_COUNT - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   cmpSync;
  logic                   hitAcc;
  logic                   verdict;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= cmpIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], cmpIn};
      end
    end
  endgenerate

  assign cmpSync = syncReg[SYNC_STAGES-1];
  assign verdict = hitAcc | (ctrl.sample & cmpSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitAcc       <= 1'b0;
      tripCount    <= '0;
      faultLatched <= 1'b0;
    end else begin
      hitAcc <= ctrl.close ? 1'b0 : verdict;
      if (ctrl.close) begin
        if (verdict) begin
          if (tripCount != CNT_TOP) tripCount <= tripCount + 1'b1;
          if (tripCount == CNT_PREV) faultLatched <= 1'b1;
        end else begin
          tripCount <= '0;
        end
      end
    end
  end

  assign gateOut = gateIn & ~faultLatched;
endmodule

// File: rtl/ovfault_qualifier.sv
module ovfault_qualifier
  import ovq_pkg::*;
#(
  parameter int HOLDOFF_TICKS = 200,
  parameter int WINDOW_TICKS  = 50,
  parameter int TRIP_COUNT    = 4,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W        = $clog2(TRIP_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateIn,
  input  logic             cmpIn,
  output logic             gateOut,
  output logic             strobe,
  output logic [CNT_W-1:0] tripCount,
  output logic             faultLatched
);
  qualCtrl_t ctrl;

  ovq_control #(
    .HOLDOFF_TICKS(HOLDOFF_TICKS),
    .WINDOW_TICKS (WINDOW_TICKS)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .gateIn(gateIn),
    .ctrl  (ctrl),
    .strobe(strobe)
  );

  ovq_datapath #(
    .TRIP_COUNT (TRIP_COUNT),
    .SYNC_STAGES(SYNC_STAGES),
    .CNT_W      (CNT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmpIn       (cmpIn),
    .gateIn      (gateIn),
    .ctrl        (ctrl),
    .tripCount   (tripCount),
    .faultLatched(faultLatched),
    .gateOut     (gateOut)
  );
endmodule

// File: rtl/ovq_checker.sv
module ovq_checker #(
  parameter int TRIP_COUNT = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateIn,
  input logic             gateOut,
  input logic             strobe,
  input logic [CNT_W-1:0] tripCount,
  input logic             faultLatched
);
  // R6: the window never samples while the switch is on
  p_strobe_off_when_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> !gateIn);

  // R8: fault is sticky
  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |=> faultLatched);

  // R8: gate blanked while faulted
  p_gate_blanked_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> !gateOut);

  // R10: gate passes through when healthy
  p_gate_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    !faultLatched |-> (gateOut == gateIn));

  // R5: counter never exceeds the threshold
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    tripCount <= CNT_W'(TRIP_COUNT));

  // R3 and R4: the counter only steps up by one or clears
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tripCount != $past(tripCount)) |->
      ((tripCount == '0) || (tripCount == $past(tripCount) + 1'b1)));

  // R5: fault rises together with the counter reaching threshold
  p_fault_at_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> (tripCount == CNT_W'(TRIP_COUNT)));
endmodule

bind ovfault_qualifier ovq_checker #(
  .TRIP_COUNT(TRIP_COUNT),
  .CNT_W     (CNT_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .gateIn      (gateIn),
  .gateOut     (gateOut),
  .strobe      (strobe),
  .tripCount   (tripCount),
  .faultLatched(faultLatched)
);

// File: tb/sim_ovfault_qualifier.sv
`timescale 1ns/1ps
module sim_ovfault_qualifier;
  localparam int HOLD = 6;
  localparam int WIN  = 3;
  localparam int TRIP = 4;
  localparam int CW   = $clog2(TRIP + 1);
  localparam int LOWN = 14;  // gate-low clocks for a full cycle

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          gateIn = 1'b1;
  logic          cmpIn = 1'b0;
  logic          gateOut;
  logic          strobe;
  logic [CW-1:0] tripCount;
  logic          faultLatched;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;
  int stbFirst;
  int stbLen;

  always #2 clk = ~clk;  // 250 MHz

  ovfault_qualifier #(
    .HOLDOFF_TICKS(HOLD),
    .WINDOW_TICKS (WIN),
    .TRIP_COUNT   (TRIP),
    .SYNC_STAGES  (2)
  ) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .gateIn      (gateIn),
    .cmpIn       (cmpIn),
    .gateOut     (gateOut),
    .strobe      (strobe),
    .tripCount   (tripCount),
    .faultLatched(faultLatched)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN   = 1'b0;
    gateIn = 1'b1;
    cmpIn  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // one switching cycle: gate low for lowLen clocks, then high for 4;
  // cmpIn high for clock offsets pLo..pHi (offset 0 = falling-edge clock)
  task automatic swCycle(input int lowLen, input int pLo, input int pHi);
    stbFirst = -1;
    stbLen   = 0;
    for (int i = 0; i < lowLen + 4; i++) begin
      @(negedge clk);
      if (strobe) begin
        if (stbFirst < 0) stbFirst = i;
        stbLen++;
      end
      gateIn = (i < lowLen) ? 1'b0 : 1'b1;
      cmpIn  = (i >= pLo && i <= pHi) ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    cmpIn = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !finished) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    doReset();
    // R9: reset state
    check("R9 strobe", int'(strobe), 0);
    check("R9 tripCount", int'(tripCount), 0);
    check("R9 fault", int'(faultLatched), 0);
    // R10: gate passes
    check("R10 gateOut high", int'(gateOut), 1);
    @(negedge clk); gateIn = 1'b0; #1;
    check("R10 gateOut low", int'(gateOut), 0);
    @(negedge clk); gateIn = 1'b1;
    @(negedge clk);

    // R1, R2: sweep a one-clock comparator pulse over every offset
    for (int p = 0; p <= HOLD + WIN + 2; p++) begin
      doReset();
      swCycle(LOWN, p, p);
      check($sformatf("R2 pulse@%0d", p), int'(tripCount),
            (p >= HOLD - 1 && p <= HOLD + WIN - 2) ? 1 : 0);
      check("R1 strobe start", stbFirst, HOLD + 1);
      check("R1 strobe length", stbLen, WIN);
    end

    // R3, R4: two tripping cycles then a clean one
    doReset();
    swCycle(LOWN, 0, LOWN - 1);
    check("R3 count after 1", int'(tripCount), 1);
    swCycle(LOWN, 0, LOWN - 1);
    check("R3 count after 2", int'(tripCount), 2);
    swCycle(LOWN, 99, 99);
    check("R4 cleared by miss", int'(tripCount), 0);
    check("R4 no fault", int'(faultLatched), 0);
    // spike outside the window only: still a miss
    swCycle(LOWN, 0, HOLD - 2);
    check("R4 early spike ignored", int'(tripCount), 0);

    // R5, R8: run to the threshold
    for (int n = 1; n <= TRIP - 1; n++) begin
      swCycle(LOWN, 0, LOWN - 1);
      check("R3 run count", int'(tripCount), n);
      check("R5 no early fault", int'(faultLatched), 0);
    end
    swCycle(LOWN, 0, LOWN - 1);
    check("R5 count at threshold", int'(tripCount), TRIP);
    check("R5 fault set", int'(faultLatched), 1);
    check("R8 gate blanked", int'(gateOut), int'(1'b0));
    check("R8 gateIn high", int'(gateIn), 1);
    swCycle(LOWN, 0, LOWN - 1);
    check("R5 saturated", int'(tripCount), TRIP);
    swCycle(LOWN, 99, 99);
    check("R8 fault sticky", int'(faultLatched), 1);
    check("R8 gate still blanked", int'(gateOut), 0);
    doReset();
    check("R8 reset clears fault", int'(faultLatched), 0);
    check("R10 gate restored", int'(gateOut), 1);

    // R6: gate rises while the window is open
    swCycle(LOWN, 0, LOWN - 1);
    check("R6 precondition", int'(tripCount), 1);
    swCycle(HOLD + 2, HOLD, HOLD);
    check("R6 pulse after rise not seen", int'(tripCount), 0);
    swCycle(HOLD + 2, HOLD - 1, HOLD - 1);
    check("R6 pulse before rise seen", int'(tripCount), 1);
    check("R6 strobe cut short", stbLen, 2);

    // R7: gate rises during the hold-off
    swCycle(3, 0, 20);
    check("R7 hold-off abort is a miss", int'(tripCount), 0);
    check("R7 no strobe", stbLen, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule